// File: doc/BRIEF.md
# Banked Data Byte-Order and Alignment Control

This block holds the data byte-order and alignment control state of a 32-bit core. It keeps the strict-alignment bit, the unaligned-access enable bit and the exception-endian bit twice, once for the secure world and once for the non-secure world. It also keeps one global memory-endian bit that only the secure world may change. The active world's copies are shown on plain output pins.

A one-bit data-endian flag decides whether data crossing the load/store path is byte-reversed. The flag is set and cleared by explicit commands. On exception entry it is reloaded from the exception-endian copy of the world that is active.

Load data and store data each flow through their own valid/ready stream. Each stream is a combinational pass-through with the byte transform applied. The output valid follows the input valid, and the input ready follows the output ready, in the same cycle. A stalled beat therefore stays on the input until the consumer accepts it, and nothing is stored inside the block. Load beats marked as instruction fetches are never reordered.

Top module: `byte_order_unit`

## Requirements
- R1: After reset the strict-alignment, unaligned-enable and exception-endian copies of both worlds, the global memory-endian bit and the data-endian flag all read zero.
- R2: A configuration write (`cfg_we`) stores `cfg_wdata` bit 0 (strict alignment), bit 1 (unaligned enable) and bit 2 (exception endian) into the copy of the world given by `in_secure`. The change is visible on the `act_*` outputs from the next cycle. The other world's copy does not change. The `act_*` outputs always show the copy of the world that is currently active.
- R3: `cfg_wdata` bit 3 is written into the global memory-endian bit only when `in_secure` is 1. A write from the non-secure world leaves that bit unchanged.
- R4: A pulse on `exc_entry` loads the data-endian flag, from the next cycle, with the exception-endian copy of the world that is active in the pulse cycle.
- R5: `e_set` sets the data-endian flag and `e_clr` clears it, from the next cycle. When both are high, set wins.
- R6: When `exc_entry` is high in the same cycle as `e_set` or `e_clr`, the exception-entry update decides the flag.
- R7: While the flag is 1, each stream reorders its data by size code. Codes 2'b10 and 2'b11 (word) reverse all four bytes. Code 2'b01 (halfword) swaps bytes 0 and 1 and passes bytes 2 and 3 unchanged. Code 2'b00 (byte) passes the data unchanged. While the flag is 0, data passes unchanged.
- R8: A load beat with `ld_in_fetch` high passes unchanged whatever the flag and the size.
- R9: On each stream the output valid equals the input valid and the input ready equals the output ready, in the same cycle. Holding ready low keeps the beat waiting at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_secure | input | 1 | 1 while the secure world is active |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Write data: bit0 strict, bit1 unaligned, bit2 exception endian, bit3 global endian |
| exc_entry | input | 1 | Exception-entry strobe |
| e_set | input | 1 | Set the data-endian flag |
| e_clr | input | 1 | Clear the data-endian flag |
| ld_in_valid | input | 1 | Load beat valid from memory side |
| ld_in_ready | output | 1 | Load beat accepted |
| ld_in_data | input | 32 | Load data from memory side |
| ld_in_size | input | 2 | Load access size code |
| ld_in_fetch | input | 1 | Beat is instruction data (never reordered) |
| ld_out_valid | output | 1 | Load beat valid to register file |
| ld_out_ready | input | 1 | Register file side ready |
| ld_out_data | output | 32 | Reordered load data |
| st_in_valid | input | 1 | Store beat valid from register file |
| st_in_ready | output | 1 | Store beat accepted |
| st_in_data | input | 32 | Store data from register file |
| st_in_size | input | 2 | Store access size code |
| st_out_valid | output | 1 | Store beat valid to memory |
| st_out_ready | input | 1 | Memory side ready |
| st_out_data | output | 32 | Reordered store data |
| act_strict_align | output | 1 | Active world's strict-alignment bit |
| act_unalign_en | output | 1 | Active world's unaligned-enable bit |
| act_exc_endian | output | 1 | Active world's exception-endian bit |
| glob_mem_endian | output | 1 | Global memory-endian bit |
| data_endian | output | 1 | Data-endian flag |

## Verification
A corrupted banked copy shows on the `act_*` pins in the first cycle its world is selected. A flag loaded from the wrong world's copy shows on `data_endian` one cycle after the exception strobe. The same wrong flag reverses or fails to reverse the very next load or store word. A non-secure write that leaks into the global bit appears on `glob_mem_endian` in the following cycle. A lost priority between exception entry and the set/clear commands shows as the wrong flag level in that same next cycle.

// File: rtl/bo_pkg.sv
package bo_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  localparam int CFG_W      = 4;
  localparam int CFG_STRICT = 0;
  localparam int CFG_UNAL   = 1;
  localparam int CFG_EXCEND = 2;
  localparam int CFG_GEND   = 3;

  typedef struct packed {
    logic exc_endian;
    logic unal_en;
    logic strict;
  } bank_t;
endpackage

// File: rtl/bo_bank_regs.sv
module bo_bank_regs
  import bo_pkg::*;
#(
  parameter int NWORLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             world,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output bank_t            active,
  output logic             gend
);
  localparam int SEC_IDX = NWORLD - 1;

  bank_t bank_q [NWORLD];
  logic  gend_q;

  for (genvar w = 0; w < NWORLD; w++) begin : g_world
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[w] <= '0;
      end else if (we && (int'(world) == w)) begin
        bank_q[w].strict     <= wdata[CFG_STRICT];
        bank_q[w].unal_en    <= wdata[CFG_UNAL];
        bank_q[w].exc_endian <= wdata[CFG_EXCEND];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                gend_q <= 1'b0;
    else if (we && (int'(world) == SEC_IDX))   gend_q <= wdata[CFG_GEND];
  end

  assign active = bank_q[int'(world)];
  assign gend   = gend_q;
endmodule

// File: rtl/bo_flag.sv
module bo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic exc_entry,
  input  logic exc_src,
  input  logic set_cmd,
  input  logic clr_cmd,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (exc_entry) flag_q <= exc_src;
    else if (set_cmd)   flag_q <= 1'b1;
    else if (clr_cmd)   flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/bo_swap.sv
module bo_swap
  import bo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  input  logic              en,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;

  always_comb begin
    dout = din;
    if (en) begin
      unique case (acc_size_e'(size))
        SZ_HALF: begin
          dout[7:0]  = din[15:8];
          dout[15:8] = din[7:0];
        end
        SZ_WORD, SZ_WIDE: begin
          for (int i = 0; i < NB; i++) dout[i*8 +: 8] = din[(NB-1-i)*8 +: 8];
        end
        default: dout = din;
      endcase
    end
  end
endmodule

// File: rtl/byte_order_unit.sv
module byte_order_unit
  import bo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_secure,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  input  logic              exc_entry,
  input  logic              e_set,
  input  logic              e_clr,
  input  logic              ld_in_valid,
  output logic              ld_in_ready,
  input  logic [DATA_W-1:0] ld_in_data,
  input  logic [1:0]        ld_in_size,
  input  logic              ld_in_fetch,
  output logic              ld_out_valid,
  input  logic              ld_out_ready,
  output logic [DATA_W-1:0] ld_out_data,
  input  logic              st_in_valid,
  output logic              st_in_ready,
  input  logic [DATA_W-1:0] st_in_data,
  input  logic [1:0]        st_in_size,
  output logic              st_out_valid,
  input  logic              st_out_ready,
  output logic [DATA_W-1:0] st_out_data,
  output logic              act_strict_align,
  output logic              act_unalign_en,
  output logic              act_exc_endian,
  output logic              glob_mem_endian,
  output logic              data_endian
);
  bank_t active;
  logic  gend;
  logic  flag;

  bo_bank_regs #(.NWORLD(2)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .world  (in_secure),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .active (active),
    .gend   (gend)
  );

  bo_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_entry (exc_entry),
    .exc_src   (active.exc_endian),
    .set_cmd   (e_set),
    .clr_cmd   (e_clr),
    .flag      (flag)
  );

  bo_swap #(.DATA_W(DATA_W)) u_ld_swap (
    .din  (ld_in_data),
    .size (ld_in_size),
    .en   (flag & ~ld_in_fetch),
    .dout (ld_out_data)
  );

  bo_swap #(.DATA_W(DATA_W)) u_st_swap (
    .din  (st_in_data),
    .size (st_in_size),
    .en   (flag),
    .dout (st_out_data)
  );

  assign ld_out_valid     = ld_in_valid;
  assign ld_in_ready      = ld_out_ready;
  assign st_out_valid     = st_in_valid;
  assign st_in_ready      = st_out_ready;
  assign act_strict_align = active.strict;
  assign act_unalign_en   = active.unal_en;
  assign act_exc_endian   = active.exc_endian;
  assign glob_mem_endian  = gend;
  assign data_endian      = flag;
endmodule

// File: rtl/bo_checker.sv
module bo_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_secure,
  input logic              cfg_we,
  input logic              exc_entry,
  input logic              e_set,
  input logic              e_clr,
  input logic              ld_in_valid,
  input logic              ld_in_ready,
  input logic [DATA_W-1:0] ld_in_data,
  input logic              ld_in_fetch,
  input logic              ld_out_valid,
  input logic              ld_out_ready,
  input logic [DATA_W-1:0] ld_out_data,
  input logic [DATA_W-1:0] st_in_data,
  input logic [DATA_W-1:0] st_out_data,
  input logic              act_exc_endian,
  input logic              glob_mem_endian,
  input logic              data_endian
);
  a_r3_ns_gend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !in_secure) |=> $stable(glob_mem_endian));

  a_r4_exc_reload: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> (data_endian == $past(act_exc_endian)));

  a_r5_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (e_set && !exc_entry) |=> data_endian);

  a_r5_clr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (e_clr && !e_set && !exc_entry) |=> !data_endian);

  a_r7_plain_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !data_endian |-> (st_out_data == st_in_data));

  a_r8_fetch_plain: assert property (@(posedge clk) disable iff (!rst_n)
    ld_in_fetch |-> (ld_out_data == ld_in_data));

  a_r9_ld_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_out_valid == ld_in_valid) && (ld_in_ready == ld_out_ready));
endmodule

bind byte_order_unit bo_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/byte_order_unit_bench.sv
module byte_order_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_secure = 1'b0, cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        exc_entry = 1'b0, e_set = 1'b0, e_clr = 1'b0;
  logic        ld_in_valid = 1'b0, ld_in_ready, ld_in_fetch = 1'b0;
  logic [31:0] ld_in_data = '0, ld_out_data;
  logic [1:0]  ld_in_size = '0, st_in_size = '0;
  logic        ld_out_valid, ld_out_ready = 1'b0;
  logic        st_in_valid = 1'b0, st_in_ready, st_out_valid, st_out_ready = 1'b0;
  logic [31:0] st_in_data = '0, st_out_data;
  logic        act_strict_align, act_unalign_en, act_exc_endian, glob_mem_endian, data_endian;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  byte_order_unit u_byte_order_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_order(input logic [31:0] d, input logic [1:0] sz, input logic on);
    if (!on || sz == 2'b00) return d;
    if (sz == 2'b01) return {d[31:16], d[7:0], d[15:8]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(input logic sec, input logic [3:0] v);
    in_secure = sec; cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 strict", {31'd0, act_strict_align}, 0);
    chk("R1 unal", {31'd0, act_unalign_en}, 0);
    chk("R1 excend", {31'd0, act_exc_endian}, 0);
    chk("R1 gend", {31'd0, glob_mem_endian}, 0);
    chk("R1 flag", {31'd0, data_endian}, 0);
    in_secure = 1'b1; #1;
    chk("R1 secure bank", {29'd0, act_exc_endian, act_unalign_en, act_strict_align}, 0);
  endtask

  task automatic t_bank();
    cfg_write(1'b1, 4'b0111);
    chk("R2 secure copy", {29'd0, act_exc_endian, act_unalign_en, act_strict_align}, 3'b111);
    in_secure = 1'b0; #1;
    chk("R2 ns untouched", {29'd0, act_exc_endian, act_unalign_en, act_strict_align}, 3'b000);
    cfg_write(1'b0, 4'b1010);
    chk("R2 ns copy", {29'd0, act_exc_endian, act_unalign_en, act_strict_align}, 3'b010);
    chk("R3 ns gend ignored", {31'd0, glob_mem_endian}, 0);
    in_secure = 1'b1; #1;
    chk("R2 secure kept", {29'd0, act_exc_endian, act_unalign_en, act_strict_align}, 3'b111);
  endtask

  task automatic t_global();
    cfg_write(1'b1, 4'b1100);
    chk("R3 secure gend", {31'd0, glob_mem_endian}, 1);
    cfg_write(1'b0, 4'b0010);
    chk("R3 ns clear ignored", {31'd0, glob_mem_endian}, 1);
  endtask

  task automatic t_exc();
    in_secure = 1'b1; exc_entry = 1'b1; tick(); exc_entry = 1'b0;
    chk("R4 secure ee", {31'd0, data_endian}, 1);
    in_secure = 1'b0; exc_entry = 1'b1; tick(); exc_entry = 1'b0;
    chk("R4 ns ee", {31'd0, data_endian}, 0);
  endtask

  task automatic t_cmd();
    e_set = 1'b1; tick(); e_set = 1'b0;
    chk("R5 set", {31'd0, data_endian}, 1);
    e_clr = 1'b1; tick(); e_clr = 1'b0;
    chk("R5 clr", {31'd0, data_endian}, 0);
    e_set = 1'b1; e_clr = 1'b1; tick(); e_set = 1'b0; e_clr = 1'b0;
    chk("R5 both set wins", {31'd0, data_endian}, 1);
    in_secure = 1'b0; exc_entry = 1'b1; e_set = 1'b1; tick();
    exc_entry = 1'b0; e_set = 1'b0;
    chk("R6 exc over set", {31'd0, data_endian}, 0);
    in_secure = 1'b1; exc_entry = 1'b1; e_clr = 1'b1; tick();
    exc_entry = 1'b0; e_clr = 1'b0;
    chk("R6 exc over clr", {31'd0, data_endian}, 1);
  endtask

  task automatic t_swap();
    logic [31:0] pat [3] = '{32'h11223344, 32'hAABB1122, 32'hDEADBEEF};
    ld_in_valid = 1'b1; ld_out_ready = 1'b1;
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 4; s++) begin
        ld_in_data = pat[p]; ld_in_size = 2'(s); ld_in_fetch = 1'b0;
        st_in_data = ~pat[p]; st_in_size = 2'(s); #1;
        chk("R7 load", ld_out_data, ref_order(pat[p], 2'(s), 1'b1));
        chk("R7 store", st_out_data, ref_order(~pat[p], 2'(s), 1'b1));
        ld_in_fetch = 1'b1; #1;
        chk("R8 fetch plain", ld_out_data, pat[p]);
      end
    end
    ld_in_fetch = 1'b0;
    e_clr = 1'b1; tick(); e_clr = 1'b0;
    ld_in_data = 32'h01020304; ld_in_size = 2'b10; st_in_data = 32'hCAFEF00D; st_in_size = 2'b01; #1;
    chk("R7 load flag clear", ld_out_data, 32'h01020304);
    chk("R7 store flag clear", st_out_data, 32'hCAFEF00D);
  endtask

  task automatic t_stream();
    ld_in_valid = 1'b1; ld_out_ready = 1'b0; st_in_valid = 1'b0; st_out_ready = 1'b1; #1;
    chk("R9 ld stall ready", {31'd0, ld_in_ready}, 0);
    chk("R9 ld valid", {31'd0, ld_out_valid}, 1);
    chk("R9 st ready", {31'd0, st_in_ready}, 1);
    chk("R9 st valid", {31'd0, st_out_valid}, 0);
    tick();
    chk("R9 ld held", ld_out_data, 32'h01020304);
    ld_out_ready = 1'b1; #1;
    chk("R9 ld ready", {31'd0, ld_in_ready}, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_bank();
    t_global();
    t_exc();
    t_cmd();
    t_swap();
    t_stream();
    finish_run();
  end
endmodule